// File: doc/BRIEF.md
# Multiplexed LCD Drive Sequencer

This block produces the digital drive pattern for a passive multiplexed liquid-crystal panel. It visits the common electrodes one at a time, one time slot each. For every slot it takes the matching row of segment bits from a small bank of display bytes. For each common and segment electrode it emits three signals: a 2-bit level code, a phase bit and a buffer-enable bit. The analog stage turns these into voltages. That stage is not part of this block.

Software loads the display bytes through a simple write port. The sequencer copies the whole bank at the start of every pass, so a pass always shows consistent data. Every frame runs as two passes, and the second pass has the phase bits inverted. This gives the panel a waveform with no DC component. The output buffers are enabled for only a programmable part of each slot. No pin is enabled until the supply-ready input is asserted.

Top module: `lcd_mux_seq`

## Requirements
- R1: While `vlcd_ready` is high, the common line selected for the current slot has level code 3 (peak) and phase equal to the pass polarity. Every other common line has level code 1 (low intermediate) and the inverted polarity.
- R2: While `vlcd_ready` is high, a segment whose bit is 0 has level code 1 and phase equal to the pass polarity. A segment whose bit is 1 has level code 3 and the inverted polarity.
- R3: In the slot for common line c, segment s takes bit s%8 of display byte c*5 + s/8. So each common line uses its own group of five consecutive bytes.
- R4: A slot lasts 8 `tick` pulses. Passes start at common line 0. After the last slot of the selected line count, the next slot is common line 0 again. `tick` has no effect while `vlcd_ready` is low.
- R5: The pins show a copy of the display bytes taken at the start of each pass. A write during a pass changes the pins only from the next pass onward.
- R6: All buffer enables have the same value. That value is 1 while the tick position within the slot (0 to 7) is below `drive_time`. When `drive_time` is 7, the value is 1 for the whole slot. When `drive_time` is 0, the value is 0 for the whole slot.
- R7: While `vlcd_ready` is low, every enable, level code and phase bit is 0, and the sequencer returns to common line 0, tick position 0 and polarity 0. While low, the copy follows the display bytes.
- R8: `duty_sel` = n selects n+1 active common lines. Common lines above n stay at the non-selected level of R1.
- R9: At the end of each pass the polarity toggles. Every phase bit of the next pass is therefore the inverse of the phase bit at the same slot in the previous pass.
- R10: A write to byte addresses 0 to 19 stores the byte. A write to addresses 20 to 31 changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Display byte write strobe |
| wr_addr | input | 5 | Display byte address |
| wr_data | input | 8 | Display byte value |
| duty_sel | input | 2 | Active common lines minus one |
| drive_time | input | 3 | Buffer-on tick count per slot (7 = whole slot) |
| tick | input | 1 | Slot sub-tick pulse |
| vlcd_ready | input | 1 | Panel supply has reached its target |
| com_level | output | 8 | Level code per common line, 2 bits each |
| com_phase | output | 4 | Phase bit per common line |
| com_oe | output | 4 | Buffer enable per common line |
| seg_level | output | 80 | Level code per segment line, 2 bits each |
| seg_phase | output | 40 | Phase bit per segment line |
| seg_oe | output | 40 | Buffer enable per segment line |

## Verification
A slot counter that stepped wrongly would put the peak level on the wrong common line. The tick on which this first shows can be found by counting ticks from the supply-ready edge. A polarity register that failed to toggle would show one pass later, when every phase bit fails to invert. A copy taken at the wrong moment would show up either as a write that appears mid-pass or as a write that never appears after a pass boundary. A wrong tick position shows on the enables within the same slot, wherever the position crosses `drive_time`.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_PEAK = 2'd3
  } lvl_e;
endpackage

// File: rtl/lcd_data_bank.sv
module lcd_data_bank #(
  parameter int NUM_REGS = 20,
  parameter int ADDR_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  load,
  output logic [NUM_REGS*8-1:0] snap_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(r);
    logic [7:0] byte_q, byte_d, copy_q, copy_d;

    always_comb begin
      byte_d = byte_q;
      copy_d = copy_q;
      if (wr_en && (wr_addr == MY_ADDR)) byte_d = wr_data;
      if (load) copy_d = byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        copy_q <= '0;
      end else begin
        byte_q <= byte_d;
        copy_q <= copy_d;
      end
    end

    assign snap_o[r*8 +: 8] = copy_q;
  end
endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int NUM_COM = 4,
  parameter int SUB_W   = 3,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [COM_W-1:0] duty_sel,
  input  logic [SUB_W-1:0] drive_time,
  output logic [SUB_W-1:0] sub_idx,
  output logic [COM_W-1:0] com_idx,
  output logic             pol,
  output logic             pass_end,
  output logic             buf_on
);
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [COM_W-1:0] com_q, com_d;
  logic             pol_q, pol_d;
  logic             slot_end;

  assign slot_end = run && tick && (sub_q == '1);
  assign pass_end = slot_end && (com_q >= duty_sel);

  always_comb begin
    sub_d = sub_q;
    com_d = com_q;
    pol_d = pol_q;
    if (!run) begin
      sub_d = '0;
      com_d = '0;
      pol_d = 1'b0;
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
      if (slot_end) begin
        if (pass_end) begin
          com_d = '0;
          pol_d = ~pol_q;
        end else begin
          com_d = com_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      com_q <= '0;
      pol_q <= 1'b0;
    end else begin
      sub_q <= sub_d;
      com_q <= com_d;
      pol_q <= pol_d;
    end
  end

  assign buf_on  = run && ((drive_time == '1) || (sub_q < drive_time));
  assign sub_idx = sub_q;
  assign com_idx = com_q;
  assign pol     = pol_q;
endmodule

// File: rtl/lcd_pin_encoder.sv
module lcd_pin_encoder
  import lcdseq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 40,
  localparam int COM_W  = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input  logic                       run,
  input  logic                       buf_on,
  input  logic                       pol,
  input  logic [COM_W-1:0]           com_idx,
  input  logic [NUM_COM*NUM_SEG-1:0] snap,
  output logic [2*NUM_COM-1:0]       com_level,
  output logic [NUM_COM-1:0]         com_phase,
  output logic [NUM_COM-1:0]         com_oe,
  output logic [2*NUM_SEG-1:0]       seg_level,
  output logic [NUM_SEG-1:0]         seg_phase,
  output logic [NUM_SEG-1:0]         seg_oe
);
  logic [NUM_SEG-1:0] rows [NUM_COM];
  logic [NUM_SEG-1:0] row_sel;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_row
    assign rows[c] = snap[c*NUM_SEG +: NUM_SEG];
  end

  assign row_sel = rows[com_idx];

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    localparam logic [COM_W-1:0] MY_COM = COM_W'(c);
    lvl_e lvl;
    logic ph;
    always_comb begin
      lvl = LVL_GND;
      ph  = 1'b0;
      if (run) begin
        if (com_idx == MY_COM) begin
          lvl = LVL_PEAK;
          ph  = pol;
        end else begin
          lvl = LVL_LOW;
          ph  = ~pol;
        end
      end
    end
    assign com_level[2*c +: 2] = lvl;
    assign com_phase[c]        = ph;
    assign com_oe[c]           = buf_on;
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    lvl_e lvl;
    logic ph;
    always_comb begin
      lvl = LVL_GND;
      ph  = 1'b0;
      if (run) begin
        if (row_sel[s]) begin
          lvl = LVL_PEAK;
          ph  = ~pol;
        end else begin
          lvl = LVL_LOW;
          ph  = pol;
        end
      end
    end
    assign seg_level[2*s +: 2] = lvl;
    assign seg_phase[s]        = ph;
    assign seg_oe[s]           = buf_on;
  end
endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NUM_COM       = 4,
  parameter int BYTES_PER_COM = 5,
  parameter int ADDR_W        = 5,
  parameter int SUB_W         = 3
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  wr_en,
  input  logic [ADDR_W-1:0]                                     wr_addr,
  input  logic [7:0]                                            wr_data,
  input  logic [((NUM_COM > 1) ? $clog2(NUM_COM) : 1)-1:0]      duty_sel,
  input  logic [SUB_W-1:0]                                      drive_time,
  input  logic                                                  tick,
  input  logic                                                  vlcd_ready,
  output logic [2*NUM_COM-1:0]                                  com_level,
  output logic [NUM_COM-1:0]                                    com_phase,
  output logic [NUM_COM-1:0]                                    com_oe,
  output logic [2*BYTES_PER_COM*8-1:0]                          seg_level,
  output logic [BYTES_PER_COM*8-1:0]                            seg_phase,
  output logic [BYTES_PER_COM*8-1:0]                            seg_oe
);
  localparam int NUM_SEG  = BYTES_PER_COM * 8;
  localparam int NUM_REGS = NUM_COM * BYTES_PER_COM;
  localparam int COM_W    = (NUM_COM > 1) ? $clog2(NUM_COM) : 1;

  logic [SUB_W-1:0]       sub_idx;
  logic [COM_W-1:0]       com_idx;
  logic                   pol;
  logic                   pass_end;
  logic                   buf_on;
  logic                   snap_load;
  logic [NUM_REGS*8-1:0]  snap;

  // Copy follows the bank while the supply is not ready, then only at pass ends.
  assign snap_load = !vlcd_ready || pass_end;

  lcd_data_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(snap_load), .snap_o(snap)
  );

  lcd_slot_timer #(.NUM_COM(NUM_COM), .SUB_W(SUB_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(vlcd_ready), .tick(tick),
    .duty_sel(duty_sel), .drive_time(drive_time), .sub_idx(sub_idx),
    .com_idx(com_idx), .pol(pol), .pass_end(pass_end), .buf_on(buf_on)
  );

  lcd_pin_encoder #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_enc (
    .run(vlcd_ready), .buf_on(buf_on), .pol(pol), .com_idx(com_idx),
    .snap(snap), .com_level(com_level), .com_phase(com_phase),
    .com_oe(com_oe), .seg_level(seg_level), .seg_phase(seg_phase),
    .seg_oe(seg_oe)
  );
endmodule

// File: rtl/lcd_mux_seq_chk.sv
module lcd_mux_seq_chk #(
  parameter int NUM_COM  = 4,
  parameter int NUM_SEG  = 40,
  parameter int SUB_W    = 3,
  localparam int COM_W   = (NUM_COM > 1) ? $clog2(NUM_COM) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tick,
  input logic                       vlcd_ready,
  input logic [COM_W-1:0]           duty_sel,
  input logic [SUB_W-1:0]           drive_time,
  input logic [2*NUM_COM-1:0]       com_level,
  input logic [NUM_COM-1:0]         com_oe,
  input logic [NUM_SEG-1:0]         seg_oe,
  input logic [SUB_W-1:0]           sub_idx,
  input logic [COM_W-1:0]           com_idx,
  input logic                       pol,
  input logic [NUM_COM*NUM_SEG-1:0] snap
);
  logic [NUM_COM-1:0] peak_mask;
  logic               wrap_now;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_mask
    assign peak_mask[c] = (com_level[2*c +: 2] == 2'b11);
  end

  assign wrap_now = vlcd_ready && tick && (sub_idx == '1) && (com_idx >= duty_sel);

  a_r7_pins_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    !vlcd_ready |-> (com_oe == '0 && seg_oe == '0 && com_level == '0));

  a_r1_single_peak_com: assert property (@(posedge clk) disable iff (!rst_n)
    vlcd_ready |-> $countones(peak_mask) == 1);

  a_r4_com_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (vlcd_ready && tick && sub_idx == '1 && com_idx < duty_sel)
      |=> com_idx == $past(com_idx) + 1'b1);

  a_r9_polarity_flip: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_now |=> (pol != $past(pol)) && (com_idx == '0));

  a_r5_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vlcd_ready && !wrap_now) |=> $stable(snap));

  a_r6_enables_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (com_oe == '0 && seg_oe == '0) || (&com_oe && &seg_oe));

  a_r6_off_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    (vlcd_ready && drive_time != '1 && sub_idx >= drive_time) |-> seg_oe == '0);
endmodule

bind lcd_mux_seq lcd_mux_seq_chk #(
  .NUM_COM(NUM_COM), .NUM_SEG(BYTES_PER_COM*8), .SUB_W(SUB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .vlcd_ready(vlcd_ready),
  .duty_sel(duty_sel), .drive_time(drive_time), .com_level(com_level),
  .com_oe(com_oe), .seg_oe(seg_oe), .sub_idx(sub_idx), .com_idx(com_idx),
  .pol(pol), .snap(snap)
);

// File: tb/tb_lcd_mux_seq.sv
module tb_lcd_mux_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  duty_sel;
  logic [2:0]  drive_time;
  logic        tick;
  logic        vlcd_ready;
  logic [7:0]  com_level;
  logic [3:0]  com_phase, com_oe;
  logic [79:0] seg_level;
  logic [39:0] seg_phase, seg_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_regs [20];
  logic [7:0] m_snap [20];
  int m_sub, m_com, m_duty, m_drive;
  bit m_pol, m_ready;

  lcd_mux_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_sel(duty_sel), .drive_time(drive_time), .tick(tick), .vlcd_ready(vlcd_ready),
    .com_level(com_level), .com_phase(com_phase), .com_oe(com_oe),
    .seg_level(seg_level), .seg_phase(seg_phase), .seg_oe(seg_oe)
  );

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected pins from the requirement text (R1, R2, R3, R6, R7).
  task automatic check_pins(string tag);
    logic [7:0]  ecl; logic [3:0] ecp, eco;
    logic [79:0] esl; logic [39:0] esp, eso;
    bit on;
    on = m_ready && (m_drive == 7 || m_sub < m_drive);
    for (int c = 0; c < 4; c++) begin
      if (!m_ready) begin ecl[2*c +: 2] = 2'd0; ecp[c] = 1'b0; end
      else if (c == m_com) begin ecl[2*c +: 2] = 2'd3; ecp[c] = m_pol; end
      else begin ecl[2*c +: 2] = 2'd1; ecp[c] = ~m_pol; end
      eco[c] = on;
    end
    for (int s = 0; s < 40; s++) begin
      bit b;
      b = m_snap[m_com*5 + s/8][s%8];
      if (!m_ready) begin esl[2*s +: 2] = 2'd0; esp[s] = 1'b0; end
      else if (b) begin esl[2*s +: 2] = 2'd3; esp[s] = ~m_pol; end
      else begin esl[2*s +: 2] = 2'd1; esp[s] = m_pol; end
      eso[s] = on;
    end
    check(com_level === ecl, {tag, " com_level"}, 80'(com_level), 80'(ecl));
    check(com_phase === ecp, {tag, " com_phase"}, 80'(com_phase), 80'(ecp));
    check(com_oe === eco,    {tag, " com_oe"},    80'(com_oe),    80'(eco));
    check(seg_level === esl, {tag, " seg_level"}, seg_level,      esl);
    check(seg_phase === esp, {tag, " seg_phase"}, 80'(seg_phase), 80'(esp));
    check(seg_oe === eso,    {tag, " seg_oe"},    80'(seg_oe),    80'(eso));
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    if (m_ready) begin
      if (m_sub == 7) begin
        m_sub = 0;
        if (m_com >= m_duty) begin
          m_com = 0; m_pol = ~m_pol; m_snap = m_regs;
        end else m_com++;
      end else m_sub++;
    end
  endtask

  task automatic write_byte(int a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a < 20) m_regs[a] = d;
    @(posedge clk); #1;
    if (!m_ready) m_snap = m_regs;
  endtask

  task automatic set_ready(bit v);
    vlcd_ready = v;
    @(posedge clk); #1;
    if (!v) begin m_sub = 0; m_com = 0; m_pol = 0; m_snap = m_regs; end
    m_ready = v;
  endtask

  task automatic set_cfg(int duty, int drv);
    duty_sel = 2'(duty); drive_time = 3'(drv);
    m_duty = duty; m_drive = drv;
    #1;
  endtask

  task automatic t_reset();
    check_pins("R7 after reset");
    do_tick();
    check_pins("R7 tick ignored while not ready");
  endtask

  task automatic t_first_slot();
    for (int r = 0; r < 20; r++) write_byte(r, 8'((r * 37 + 5) ^ (r << 4)));
    set_cfg(3, 7);
    set_ready(1);
    check_pins("R1 R2 R3 first slot");
  endtask

  task automatic t_walk();
    for (int i = 0; i < 64; i++) begin
      do_tick();
      check_pins("R3 R4 R9 walk four lines two passes");
    end
  endtask

  task automatic t_drive();
    set_cfg(3, 3);
    for (int i = 0; i < 8; i++) begin
      check_pins("R6 drive window 3");
      do_tick();
    end
    set_cfg(3, 0);
    check_pins("R6 drive time 0");
    do_tick();
    check_pins("R6 drive time 0 next tick");
    set_cfg(3, 7);
    check_pins("R6 drive time 7");
  endtask

  task automatic go_pass_start();
    while (!(m_sub == 0 && m_com == 0)) do_tick();
  endtask

  task automatic t_duty();
    go_pass_start();
    for (int d = 0; d < 3; d++) begin
      set_cfg(d, 7);
      for (int i = 0; i < 16 * (d + 1); i++) begin
        do_tick();
        check_pins("R8 R9 reduced duty");
      end
    end
    set_cfg(3, 7);
  endtask

  task automatic t_latch();
    go_pass_start();
    write_byte(0, ~m_regs[0]);
    write_byte(1, 8'hA5);
    check_pins("R5 write hidden mid pass");
    for (int i = 0; i < 32; i++) do_tick();
    check_pins("R5 write visible next pass");
  endtask

  task automatic t_bad_addr();
    go_pass_start();
    for (int a = 20; a < 32; a++) write_byte(a, 8'hFF);
    for (int i = 0; i < 32; i++) begin
      do_tick();
      check_pins("R10 high address ignored");
    end
  endtask

  task automatic t_ready_drop();
    for (int i = 0; i < 13; i++) do_tick();
    set_ready(0);
    check_pins("R7 inhibit on supply loss");
    write_byte(7, 8'h3C);
    set_ready(1);
    check_pins("R7 restart at line 0");
    for (int i = 0; i < 9; i++) do_tick();
    check_pins("R7 R3 after restart");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    duty_sel = 2'd3; drive_time = 3'd7; tick = 1'b0; vlcd_ready = 1'b0;
    for (int r = 0; r < 20; r++) begin m_regs[r] = '0; m_snap[r] = '0; end
    m_sub = 0; m_com = 0; m_duty = 3; m_drive = 7; m_pol = 0; m_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_first_slot();
    t_walk();
    t_drive();
    t_duty();
    t_latch();
    t_bad_addr();
    t_ready_drop();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule